// File: doc/BRIEF.md
# Downward Bit Search Unit

This unit takes a 32-bit data word and a start operand, and reports the highest set bit of the data word that lies strictly below a start position given by the low five bits of the operand. A start field of zero stands for the full word, so the search then covers bit 31 down to bit 0. The answer is a 32-bit bit index and a found flag. A processor uses the found flag as its carry status bit. Every other status bit and the register file sit outside this unit.

Operands arrive on a valid/ready stream and results leave on a second valid/ready stream. There is one output register between them. An operand pair is accepted when `in_valid` and `in_ready` are both high at a rising edge, and its result becomes visible on the next cycle. The input is ready whenever the output register is empty or its result is being taken in the same cycle. When the consumer holds `out_ready` low while a result is waiting, the result stays frozen and no new operand is accepted. This back-pressure reaches the producer at once, with no extra buffering.

Top module: `dbs_unit`

## Requirements
- R1: Only bits [4:0] of `in_start` count as the start field; bits [31:5] have no effect. For a nonzero start field s, the search covers bit s-1 down to bit 0.
- R2: A start field of 0 makes the search cover the whole word, bit 31 down to bit 0.
- R3: If any bit in the covered range is 1, `out_index` is the highest such bit position and `out_found` is 1.
- R4: If no bit in the covered range is 1, `out_index` is 0 and `out_found` is 0.
- R5: A result appears with `out_valid` high on the cycle after its operands are accepted.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_index` and `out_found` do not change.
- R7: After reset `out_valid`, `out_found` and `out_index` are all 0, and `in_ready` is 1.
- R8: Bits [31:5] of `out_index` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit can take an operand pair |
| in_data | input | 32 | Word to be searched |
| in_start | input | 32 | Start operand; only bits [4:0] are used |
| out_valid | output | 1 | Result waiting |
| out_ready | input | 1 | Consumer takes the result |
| out_index | output | 32 | Position of the bit found, 0 on a miss |
| out_found | output | 1 | 1 on a hit; drives the carry flag |

## Verification
The assertions assume three things about the inputs:
- Reset is applied before the first transfer.
- `in_data` and `in_start` are known values in any cycle where `in_valid` is high.
- `out_ready` may change freely from cycle to cycle.

The bench never leaves operands undefined when it raises `in_valid`. It drives every input on the falling edge, so all values are settled before the rising edge that samples them.

The random phase makes `out_ready` stall for runs of several cycles. This exercises the frozen-result rule. It also pairs sparse data words with start operands whose upper bits are random, so hits land on both sides of the start position.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int unsigned DBS_DATA_W = 32;
  localparam int unsigned DBS_OP_W   = 32;
  localparam int unsigned DBS_RES_W  = 32;
endpackage

// File: rtl/dbs_range_mask.sv
module dbs_range_mask #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  start_sel,
  output logic [DATA_W-1:0] keep_mask
);
  // A zero start field covers the whole word; otherwise keep only bits below it.
  logic wrap_all;
  assign wrap_all = (start_sel == '0);

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign keep_mask[g] = wrap_all || ((IDX_W+1)'(g) < {1'b0, start_sel});
  end
endmodule

// File: rtl/dbs_prio_enc.sv
module dbs_prio_enc #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] vec,
  output logic [IDX_W-1:0]  top_idx,
  output logic              any_set
);
  // Scan upward so the highest set bit is the one that survives.
  always_comb begin
    top_idx = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (vec[i]) top_idx = IDX_W'(i);
    end
  end

  assign any_set = |vec;
endmodule

// File: rtl/dbs_unit.sv
module dbs_unit #(
  parameter int unsigned DATA_W = dbs_pkg::DBS_DATA_W,
  parameter int unsigned OP_W   = dbs_pkg::DBS_OP_W,
  parameter int unsigned RES_W  = dbs_pkg::DBS_RES_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [OP_W-1:0]   in_start,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RES_W-1:0]  out_index,
  output logic             out_found
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0]  start_sel;
  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] masked;
  logic [IDX_W-1:0]  hit_idx;
  logic              hit_any;
  logic              accept;

  assign start_sel = in_start[IDX_W-1:0];
  assign masked    = in_data & keep_mask;

  dbs_range_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
    .start_sel (start_sel),
    .keep_mask (keep_mask)
  );

  dbs_prio_enc #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_enc (
    .vec     (masked),
    .top_idx (hit_idx),
    .any_set (hit_any)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_index <= '0;
      out_found <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_index <= RES_W'(hit_idx);
      out_found <= hit_any;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dbs_unit_chk.sv
module dbs_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OP_W   = 32,
  parameter int unsigned RES_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic [OP_W-1:0]   in_start,
  input logic             out_valid,
  input logic             out_ready,
  input logic [RES_W-1:0]  out_index,
  input logic             out_found
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] data_q;
  logic [IDX_W-1:0]  start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      start_q <= '0;
    end else if (in_valid && in_ready) begin
      data_q  <= in_data;
      start_q <= in_start[IDX_W-1:0];
    end
  end

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_index) && $stable(out_found)));

  p_stall_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_found) |-> (out_index == '0));

  p_hit_bit_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_found) |-> data_q[out_index[IDX_W-1:0]]);

  p_below_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_found && start_q != '0) |-> (out_index[IDX_W-1:0] < start_q));

  p_index_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_index < RES_W'(DATA_W));
endmodule

bind dbs_unit dbs_unit_chk #(.DATA_W(DATA_W), .OP_W(OP_W), .RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_start  (in_start),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_index (out_index),
  .out_found (out_found)
);

// File: tb/dbs_unit_bench.sv
`timescale 1ns/1ps
module dbs_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [31:0] in_start = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_index;
  logic        out_found;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  dbs_unit u_dbs_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_start(in_start), .out_valid(out_valid),
    .out_ready(out_ready), .out_index(out_index), .out_found(out_found)
  );

  // Behavioural search: walk downward from the start position.
  function automatic void ref_search(input logic [31:0] d, input logic [31:0] s,
                                     output logic [31:0] idx, output logic f);
    int top;
    top = int'(s[4:0]);
    if (top == 0) top = 32;
    idx = '0;
    f   = 1'b0;
    for (int b = top - 1; b >= 0; b--) begin
      if (!f && d[b]) begin
        idx = 32'(b);
        f   = 1'b1;
      end
    end
  endfunction

  // Cycle model of the output stage.
  logic        m_valid = 1'b0;
  logic [31:0] m_index = '0;
  logic        m_found = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] ri;
    logic        rf;
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_index <= '0;
      m_found <= 1'b0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      ref_search(in_data, in_start, ri, rf);
      m_valid <= 1'b1;
      m_index <= ri;
      m_found <= rf;
    end else if (out_ready) begin
      m_valid <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 in_ready", 32'(in_ready), 32'(!m_valid || out_ready));
      chk("R5 out_valid", 32'(out_valid), 32'(m_valid));
      chk("R8 index upper bits", {5'b0, out_index[31:5]}, 32'h0);
      if (m_valid) begin
        chk("R3/R4 out_index", out_index, m_index);
        chk("R3/R4 out_found", 32'(out_found), 32'(m_found));
      end
    end
  end

  task automatic send_and_check(input logic [31:0] d, input logic [31:0] s,
                                input logic [31:0] ei, input logic ef, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_start = s;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, 32'(out_valid), 32'h1);
    chk({tag, " index"}, out_index, ei);
    chk({tag, " found"}, 32'(out_found), 32'(ef));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 out_valid", 32'(out_valid), 32'h0);
    chk("R7 out_index", out_index, 32'h0);
    chk("R7 out_found", 32'(out_found), 32'h0);
    chk("R7 in_ready", 32'(in_ready), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    send_and_check(32'h8000_0001, 32'h0,         32'd31, 1'b1, "R2 wrap to bit 31");
    send_and_check(32'h8000_0001, 32'd31,        32'd0,  1'b1, "R3 skip bit 31");
    send_and_check(32'h0000_00F0, 32'd4,         32'd0,  1'b0, "R4 miss below 4");
    send_and_check(32'h0000_00F0, 32'hFFFF_FFE5, 32'd4,  1'b1, "R1 upper start bits ignored");
    send_and_check(32'h0000_00F0, 32'hABCD_EF00, 32'd7,  1'b1, "R1 upper bits with zero field");
    send_and_check(32'h0000_0001, 32'd1,         32'd0,  1'b1, "R3 lowest bit");
    send_and_check(32'h0000_0002, 32'd1,         32'd0,  1'b0, "R4 only bit 0 covered");
    send_and_check(32'h0000_0000, 32'h0,         32'd0,  1'b0, "R4 empty word");
    send_and_check(32'hFFFF_FFFF, 32'd17,        32'd16, 1'b1, "R3 dense word");

    // R6: stall with a waiting result
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 32'h0000_1000; in_start = 32'd20;
    @(negedge clk);
    in_data = 32'h0000_0004; in_start = 32'd0;
    repeat (3) begin
      @(negedge clk);
      chk("R6 stalled in_ready", 32'(in_ready), 32'h0);
      chk("R6 held index", out_index, 32'd12);
      chk("R6 held found", 32'(out_found), 32'h1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 next result after stall", out_index, 32'd2);
    @(negedge clk);

    // Random traffic with back-pressure
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      in_valid  = ($urandom_range(0, 3) != 0);
      out_ready = ($urandom_range(0, 2) != 0);
      case ($urandom_range(0, 3))
        0: in_data = '0;
        1: in_data = $urandom & $urandom & $urandom;
        2: in_data = 32'h1 << $urandom_range(0, 31);
        default: in_data = $urandom;
      endcase
      in_start = $urandom;
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule